// File: doc/BRIEF.md
# DMA Channel Control and Status

This block is the control core of one DMA channel. Software programs it through a small register port: a mode word carrying a start bit, a one-shot repeat bit, a transfer-kind bit and an error-tolerance bit, a status word with busy, error and completion flags, and two descriptor address words. The block turns edges on the start bit into launch, pause and resume commands, and sequences an external segment mover through a start pulse and a halt level.

The sequencer has four states. CH_IDLE waits for a start edge and moves to CH_LAUNCH. CH_LAUNCH drives a one-cycle start pulse carrying the current descriptor address and moves to CH_RUN, or to CH_HALT if a stop edge arrived during the pulse. CH_RUN waits for the mover. On an error with errors not tolerated it returns to CH_IDLE. On a completed segment it returns to CH_IDLE when the transfer is over, or moves to CH_LAUNCH for the next segment. A stop edge moves it to CH_HALT. CH_HALT raises the halt level. A start edge resumes to CH_RUN, and an error drops it to CH_IDLE.

In chained operation each completed segment hands back a link address. The block loads that link into the current address, unless the repeat bit is set. In that case the same segment runs once more and the repeat bit clears itself. The mover must not report completion while halted.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset every register reads zero, the channel is idle, and neither the start pulse nor the halt level is asserted.
- R2: Writing the mode word (select 0) so that the start bit (bit 0) goes from 0 to 1 while idle makes the channel busy (status bit 2). It also drives a one-cycle start pulse carrying the current address (select 2) in the cycle after the write.
- R3: Writing the start bit from 1 to 0 while busy raises the halt level. Busy stays set.
- R4: Writing the start bit from 0 to 1 while halted drops the halt level and issues no new start pulse. Busy stays set.
- R5: Writing the start bit from 1 to 0 while idle has no effect: no start pulse, no halt, and busy stays clear.
- R6: When the transfer completes, hardware clears the start bit and busy, and sets the end-of-chain flag (status bit 0).
- R7: With the error-tolerance bit (mode bit 3) at 0, a mover error sets the error flag (status bit 7) and clears busy, and the start bit stays as written.
- R8: With the error-tolerance bit at 1, a mover error sets the error flag, the channel stays busy without halting, and the transfer runs to completion.
- R9: With the transfer-kind bit (mode bit 2) at 1 (direct), one segment completion ends the transfer, whatever the last-segment indication says.
- R10: With the transfer-kind bit at 0 (chained), a completion not marked last sets the end-of-segment flag (status bit 1). It then issues a new start pulse at the link address returned with the completion, and that link also becomes the next-address word (select 3).
- R11: In chained mode, a set repeat bit (mode bit 1) at a segment completion relaunches the same address and clears the repeat bit, so only one repeat occurs.
- R12: In the status word, writing 1 to the error, end-of-segment or end-of-chain flag clears it, and writing 0 leaves it unchanged. Busy cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Write select: 0 mode, 1 status, 2 current address, 3 next address |
| reg_wdata | input | DW | Write data |
| reg_rsel | input | 2 | Read select, same encoding as reg_sel |
| reg_rdata | output | DW | Read data, combinational from reg_rsel |
| mv_start | output | 1 | One-cycle segment start pulse |
| mv_addr | output | AW | Descriptor address for the segment |
| mv_halt | output | 1 | Halt request level to the mover |
| mv_done | input | 1 | One-cycle segment completion |
| mv_err | input | 1 | One-cycle mover error |
| mv_last | input | 1 | Qualifies mv_done: the segment was the last of the chain |
| mv_link | input | AW | Link address valid with mv_done |

## Verification
The bench builds the block with a 16-bit address width inside a 32-bit data word. This checks that address readback is zero-extended and that random link values use the full address range. Directed cases cover each start-bit edge in each busy state, errors with and without tolerance, and status clearing. Random chains of one to four segments, with the repeat bit set at random points, check the launched address sequence against a bench model.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [1:0] {
        CH_IDLE   = 2'd0,
        CH_LAUNCH = 2'd1,
        CH_RUN    = 2'd2,
        CH_HALT   = 2'd3
    } ch_state_e;

    localparam int SEL_W = 2;
    localparam logic [SEL_W-1:0] SEL_MODE = 2'd0;
    localparam logic [SEL_W-1:0] SEL_STAT = 2'd1;
    localparam logic [SEL_W-1:0] SEL_CUR  = 2'd2;
    localparam logic [SEL_W-1:0] SEL_NXT  = 2'd3;

    localparam int MB_CS  = 0;
    localparam int MB_CC  = 1;
    localparam int MB_CTM = 2;
    localparam int MB_TEM = 3;

    localparam int SB_EOC  = 0;
    localparam int SB_EOS  = 1;
    localparam int SB_BUSY = 2;
    localparam int SB_TE   = 7;

    typedef struct packed {
        logic seg_done;
        logic chain_end;
        logic err;
        logic repeat_seg;
        logic advance;
        logic end_xfer;
    } ch_evt_t;

endpackage

// File: rtl/dma_start_decode.sv
module dma_start_decode
    import dma_chan_pkg::*;
(
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic             wr_cs,
    input  logic             cs_q,
    output logic             cs_rise,
    output logic             cs_fall
);

    logic mode_wr;

    always_comb begin
        mode_wr = wr_en && (wr_sel == SEL_MODE);
        cs_rise = mode_wr && wr_cs && !cs_q;
        cs_fall = mode_wr && !wr_cs && cs_q;
    end

endmodule

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
    import dma_chan_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cs_rise,
    input  logic    cs_fall,
    input  logic    ctm,
    input  logic    cc,
    input  logic    tem,
    input  logic    seg_done,
    input  logic    seg_err,
    input  logic    seg_last,
    output logic    busy,
    output logic    seg_start,
    output logic    seg_halt,
    output ch_evt_t evt
);

    ch_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        evt     = '0;
        unique case (state_q)
            CH_IDLE: begin
                if (cs_rise) state_d = CH_LAUNCH;
            end
            CH_LAUNCH: begin
                state_d = cs_fall ? CH_HALT : CH_RUN;
            end
            CH_RUN: begin
                if (seg_err) evt.err = 1'b1;
                if (seg_err && !tem) begin
                    state_d = CH_IDLE;
                end else if (seg_done) begin
                    evt.seg_done = 1'b1;
                    if (ctm || seg_last) begin
                        evt.chain_end = 1'b1;
                        evt.end_xfer  = 1'b1;
                        state_d       = CH_IDLE;
                    end else begin
                        state_d = CH_LAUNCH;
                        if (cc) evt.repeat_seg = 1'b1;
                        else    evt.advance    = 1'b1;
                    end
                end else if (cs_fall) begin
                    state_d = CH_HALT;
                end
            end
            CH_HALT: begin
                if (seg_err) begin
                    evt.err = 1'b1;
                    state_d = CH_IDLE;
                end else if (cs_rise) begin
                    state_d = CH_RUN;
                end
            end
            default: state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        busy      = (state_q != CH_IDLE);
        seg_start = (state_q == CH_LAUNCH);
        seg_halt  = (state_q == CH_HALT);
    end

    // R2
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_start |=> !seg_start);

    // R7
    err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_RUN && seg_err && !tem) |=> !busy);

    // R5
    idle_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cs_fall) |=> (!busy && !seg_start));

    // R3
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_RUN && cs_fall && !seg_err && !seg_done) |=> (seg_halt && busy));

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [DW-1:0]    wr_data,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [DW-1:0]    rd_data,
    input  logic             busy,
    input  ch_evt_t          evt,
    input  logic [AW-1:0]    seg_link,
    output logic             cs,
    output logic             cc,
    output logic             ctm,
    output logic             tem,
    output logic [AW-1:0]    cur_addr
);

    logic          st_te, st_eos, st_eoc;
    logic [AW-1:0] nxt_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs       <= 1'b0;
            cc       <= 1'b0;
            ctm      <= 1'b0;
            tem      <= 1'b0;
            st_te    <= 1'b0;
            st_eos   <= 1'b0;
            st_eoc   <= 1'b0;
            cur_addr <= '0;
            nxt_addr <= '0;
        end else begin
            if (wr_en && wr_sel == SEL_MODE) begin
                cs  <= wr_data[MB_CS];
                cc  <= wr_data[MB_CC];
                ctm <= wr_data[MB_CTM];
                tem <= wr_data[MB_TEM];
            end
            if (evt.repeat_seg) cc <= 1'b0;
            if (evt.end_xfer)   cs <= 1'b0;

            if (wr_en && wr_sel == SEL_STAT) begin
                st_te  <= st_te  & ~wr_data[SB_TE];
                st_eos <= st_eos & ~wr_data[SB_EOS];
                st_eoc <= st_eoc & ~wr_data[SB_EOC];
            end
            if (evt.err)       st_te  <= 1'b1;
            if (evt.seg_done)  st_eos <= 1'b1;
            if (evt.chain_end) st_eoc <= 1'b1;

            if (wr_en && wr_sel == SEL_CUR) cur_addr <= wr_data[AW-1:0];
            if (evt.advance)                cur_addr <= seg_link;

            if (wr_en && wr_sel == SEL_NXT)      nxt_addr <= wr_data[AW-1:0];
            if (evt.advance || evt.repeat_seg)   nxt_addr <= seg_link;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_sel)
            SEL_MODE: begin
                rd_data[MB_CS]  = cs;
                rd_data[MB_CC]  = cc;
                rd_data[MB_CTM] = ctm;
                rd_data[MB_TEM] = tem;
            end
            SEL_STAT: begin
                rd_data[SB_TE]   = st_te;
                rd_data[SB_BUSY] = busy;
                rd_data[SB_EOS]  = st_eos;
                rd_data[SB_EOC]  = st_eoc;
            end
            SEL_CUR: rd_data[AW-1:0] = cur_addr;
            SEL_NXT: rd_data[AW-1:0] = nxt_addr;
            default: rd_data = '0;
        endcase
    end

    // R8
    te_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt.err |=> st_te);

    // R11
    cc_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt.repeat_seg |=> !cc);

    // R6
    cs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt.end_xfer |=> !cs);

endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
    import dma_chan_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_sel,
    input  logic [DW-1:0] reg_wdata,
    input  logic [1:0]    reg_rsel,
    output logic [DW-1:0] reg_rdata,
    output logic          mv_start,
    output logic [AW-1:0] mv_addr,
    output logic          mv_halt,
    input  logic          mv_done,
    input  logic          mv_err,
    input  logic          mv_last,
    input  logic [AW-1:0] mv_link
);

    logic    cs, cc, ctm, tem, busy;
    logic    cs_rise, cs_fall;
    ch_evt_t evt;

    dma_start_decode u_dec (
        .wr_en   (reg_wr),
        .wr_sel  (reg_sel),
        .wr_cs   (reg_wdata[MB_CS]),
        .cs_q    (cs),
        .cs_rise (cs_rise),
        .cs_fall (cs_fall)
    );

    dma_chan_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_rise   (cs_rise),
        .cs_fall   (cs_fall),
        .ctm       (ctm),
        .cc        (cc),
        .tem       (tem),
        .seg_done  (mv_done),
        .seg_err   (mv_err),
        .seg_last  (mv_last),
        .busy      (busy),
        .seg_start (mv_start),
        .seg_halt  (mv_halt),
        .evt       (evt)
    );

    dma_chan_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .wr_sel   (reg_sel),
        .wr_data  (reg_wdata),
        .rd_sel   (reg_rsel),
        .rd_data  (reg_rdata),
        .busy     (busy),
        .evt      (evt),
        .seg_link (mv_link),
        .cs       (cs),
        .cc       (cc),
        .ctm      (ctm),
        .tem      (tem),
        .cur_addr (mv_addr)
    );

endmodule

// File: tb/dma_chan_ctl_bench.sv
module dma_chan_ctl_bench;

    localparam int DW = 32;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_sel = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [1:0]    reg_rsel = '0;
    logic [DW-1:0] reg_rdata;
    logic          mv_start, mv_halt;
    logic [AW-1:0] mv_addr;
    logic          mv_done = 1'b0;
    logic          mv_err = 1'b0;
    logic          mv_last = 1'b0;
    logic [AW-1:0] mv_link = '0;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    dma_chan_ctl #(.DW(DW), .AW(AW)) u_dma_chan_ctl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rsel(reg_rsel), .reg_rdata(reg_rdata),
        .mv_start(mv_start), .mv_addr(mv_addr), .mv_halt(mv_halt),
        .mv_done(mv_done), .mv_err(mv_err), .mv_last(mv_last), .mv_link(mv_link)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [31:0] v);
        reg_rsel = s;
        #1;
        v = reg_rdata;
    endtask

    task automatic done(input logic [AW-1:0] link, input logic last);
        @(negedge clk);
        mv_done = 1'b1; mv_last = last; mv_link = link;
        @(negedge clk);
        mv_done = 1'b0; mv_last = 1'b0;
    endtask

    task automatic err_pulse();
        @(negedge clk);
        mv_err = 1'b1;
        @(negedge clk);
        mv_err = 1'b0;
    endtask

    function automatic logic [31:0] next_exp(input logic [31:0] cur, input logic [31:0] link, input logic rep);
        return rep ? cur : link;
    endfunction

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL R1 watchdog act=hung exp=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] exp_a;
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(0, v); chk("R1 mode", v, 0);
        rd(1, v); chk("R1 status", v, 0);
        rd(2, v); chk("R1 cur", v, 0);
        chk("R1 start", {31'b0, mv_start}, 0);
        chk("R1 halt", {31'b0, mv_halt}, 0);

        // R2 / R9 / R6 direct single transfer
        wr(2, 32'h1000);
        wr(0, 32'h5);
        chk("R2 start pulse", {31'b0, mv_start}, 1);
        chk("R2 addr", {16'b0, mv_addr}, 32'h1000);
        rd(1, v); chk("R2 busy", v, 32'h4);
        @(negedge clk);
        chk("R2 pulse one cycle", {31'b0, mv_start}, 0);
        done(16'h7777, 1'b0);
        chk("R9 no relaunch", {31'b0, mv_start}, 0);
        rd(1, v); chk("R9 R6 status", v, 32'h3);
        rd(0, v); chk("R6 cs cleared", v, 32'h4);

        // R12 write-1-to-clear
        wr(1, 32'h2); rd(1, v); chk("R12 clear eos", v, 32'h1);
        wr(1, 32'h0); rd(1, v); chk("R12 zero keeps", v, 32'h1);
        wr(1, 32'hFF); rd(1, v); chk("R12 clear all", v, 32'h0);

        // R3 / R4 halt and resume in chained mode
        wr(2, 32'h2000);
        wr(0, 32'h1);
        chk("R2 chain start", {31'b0, mv_start}, 1);
        @(negedge clk);
        wr(0, 32'h0);
        chk("R3 halt", {31'b0, mv_halt}, 1);
        rd(1, v); chk("R3 busy held", v, 32'h4);
        wr(1, 32'h4);
        rd(1, v); chk("R12 busy not writable", v, 32'h4);
        wr(0, 32'h1);
        chk("R4 halt released", {31'b0, mv_halt}, 0);
        chk("R4 no new start", {31'b0, mv_start}, 0);
        rd(1, v); chk("R4 busy", v, 32'h4);
        done(16'h0, 1'b1);
        rd(1, v); chk("R6 chain end", v, 32'h3);
        wr(1, 32'hFF);

        // R7 / R5 error halts when not tolerated
        wr(2, 32'h3000);
        wr(0, 32'h1);
        @(negedge clk);
        err_pulse();
        rd(1, v); chk("R7 te set busy clear", v, 32'h80);
        rd(0, v); chk("R7 cs kept", v, 32'h1);
        wr(0, 32'h0);
        chk("R5 no start", {31'b0, mv_start}, 0);
        chk("R5 no halt", {31'b0, mv_halt}, 0);
        rd(1, v); chk("R5 idle", v, 32'h80);
        wr(0, 32'h1);
        chk("R2 restart", {31'b0, mv_start}, 1);
        @(negedge clk);
        done(16'h0, 1'b1);
        wr(1, 32'hFF);

        // R8 error tolerated
        wr(2, 32'h4000);
        wr(0, 32'h9);
        @(negedge clk);
        err_pulse();
        rd(1, v); chk("R8 te and busy", v, 32'h84);
        chk("R8 no halt", {31'b0, mv_halt}, 0);
        done(16'h0, 1'b1);
        rd(1, v); chk("R8 completes", v, 32'h83);
        wr(1, 32'hFF);

        // R10 / R11 random chains with random repeats
        for (int it = 0; it < 12; it++) begin
            int n;
            exp_a = {16'b0, 16'($urandom) & 16'hFFF0};
            wr(2, exp_a);
            wr(0, 32'h1);
            n = 1 + int'($urandom % 4);
            for (int i = 0; i < n; i++) begin
                logic rep;
                logic [AW-1:0] link;
                chk("R10 launch", {31'b0, mv_start}, 1);
                chk("R10 addr", {16'b0, mv_addr}, exp_a);
                @(negedge clk);
                rep = (i < n - 1) && ($urandom % 2 == 1);
                if (rep) wr(0, 32'h3);
                link = 16'($urandom);
                done(link, i == n - 1);
                if (i < n - 1) begin
                    exp_a = next_exp(exp_a, {16'b0, link}, rep);
                    rd(3, v); chk("R10 next addr", v, {16'b0, link});
                    rd(1, v); chk("R10 eos", v & 32'h2, 32'h2);
                    if (rep) begin
                        rd(0, v); chk("R11 cc cleared", v, 32'h1);
                    end
                end
            end
            rd(1, v); chk("R6 random end", v, 32'h3);
            rd(0, v); chk("R6 random cs", v, 32'h0);
            wr(1, 32'hFF);
        end

        finish_run();
    end

endmodule